// File: doc/BRIEF.md
# Serial Program Register with Holding Latch

This block takes configuration for a frequency divider over three wires: a shift clock, a serial data line and a latch enable. Every rising edge of the shift clock pushes one data bit into a 19-bit shift register. A separate set of holding registers drives the divider values and the two switch outputs. These are a 10-bit main divide value, a 7-bit swallow value and a 2-bit switch field.

The holding registers copy the shift register on every system clock cycle in which the latch enable is high. While the enable is low, a complete new frame can be shifted in and the active programming does not change. In normal use the enable rests low and is pulsed high once after a frame, to transfer it.

All three serial inputs are sampled on the system clock `clk`. The shift clock edge is found by comparing the current sample with the previous one. The divider counters that consume these values are not part of this block.

Top module: `serial_prog_reg`

## Requirements
- R1: Synchronous active-high reset clears the shift register, the main value, the swallow value and both switch outputs to zero.
- R2: One bit is shifted for each low-to-high change of `sclk_i` seen on successive `clk` edges. A level held high or low shifts nothing, and so does a falling change. A shift clock that is already high when reset is released does not count as a rising change.
- R3: A frame is 19 bits. The first two bits shifted form the switch field. The next ten form the main value, most significant bit first. The last seven form the swallow value, most significant bit first.
- R4: On every `clk` edge at which `le_i` is high, the outputs take the frame then held in the shift register, and they show it after that edge.
- R5: While `le_i` is low, `n_o`, `a_o` and `sw_o` keep their values, whatever is shifted.
- R6: When a shift and a transfer fall on the same `clk` edge, the outputs take the shift register contents from before that shift.
- R7: When more than 19 bits are shifted, the earliest bits are lost. Only the 19 most recent bits count.
- R8: `sw_o[1]` carries the first switch bit shifted and `sw_o[0]` carries the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial shift clock, sampled on `clk` |
| sdata_i | input | 1 | Serial data, taken on a detected shift clock rise |
| le_i | input | 1 | Latch enable; high copies the frame to the outputs |
| n_o | output | 10 | Latched main divide value |
| a_o | output | 7 | Latched swallow value |
| sw_o | output | 2 | Latched switch outputs |

## Verification
The bench targets several corner cases, and each has its own failure symptom.

- Shift clock held high for many cycles: a design that shifts on the level would fill the register with copies of one bit.
- Shift clock already high at reset release: a design that resets its edge history to low would take a phantom bit.
- Transfer and shift on the same edge: a design that forwards the new bit would show a frame offset by one position.
- Long runs shifted with the enable low, and frames longer than 19 bits: a design whose outputs leak, or whose field slicing is reversed, would differ from the bench model on the very next cycle.

// File: rtl/spr_pkg.sv
package spr_pkg;
  // Default field widths of one programming frame
  parameter int unsigned DEF_SW_W = 2;
  parameter int unsigned DEF_N_W  = 10;
  parameter int unsigned DEF_A_W  = 7;
endpackage

// File: rtl/spr_edge_detect.sv
module spr_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  // History resets high so a level already high at release is not an edge
  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b1;
    else     sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;

  // R2
  single_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/spr_shift.sv
module spr_shift #(
  parameter int unsigned WIDTH = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] frame_o
);
  logic [WIDTH-1:0] sr_q;

  // Newest bit enters at bit 0; the oldest bit leaves from the top
  always_ff @(posedge clk) begin
    if (rst)           sr_q <= '0;
    else if (shift_en) sr_q <= {sr_q[WIDTH-2:0], din};
  end

  assign frame_o = sr_q;

  // R1
  sr_reset_chk: assert property (@(posedge clk) rst |=> frame_o == '0);
  // R2
  sr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(frame_o));
  // R7
  sr_newest_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> frame_o[0] == $past(din));
endmodule

// File: rtl/spr_hold.sv
module spr_hold #(
  parameter int unsigned SW_W = 2,
  parameter int unsigned N_W  = 10,
  parameter int unsigned A_W  = 7,
  localparam int unsigned FW  = SW_W + N_W + A_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [FW-1:0]   frame_i,
  output logic [N_W-1:0]  n_o,
  output logic [A_W-1:0]  a_o,
  output logic [SW_W-1:0] sw_o
);
  // Field positions: earliest-shifted field sits at the top of the frame
  localparam int unsigned A_LO  = 0;
  localparam int unsigned N_LO  = A_W;
  localparam int unsigned SW_LO = A_W + N_W;

  logic [N_W-1:0]  n_q;
  logic [A_W-1:0]  a_q;
  logic [SW_W-1:0] sw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_q  <= '0;
      a_q  <= '0;
      sw_q <= '0;
    end else if (load) begin
      n_q  <= frame_i[N_LO  +: N_W];
      a_q  <= frame_i[A_LO  +: A_W];
      sw_q <= frame_i[SW_LO +: SW_W];
    end
  end

  assign n_o  = n_q;
  assign a_o  = a_q;
  assign sw_o = sw_q;

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable({n_o, a_o, sw_o}));
  // R4
  hold_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> {sw_o, n_o, a_o} == $past(frame_i));
endmodule

// File: rtl/serial_prog_reg.sv
module serial_prog_reg
  import spr_pkg::*;
#(
  parameter int unsigned SW_W = DEF_SW_W,
  parameter int unsigned N_W  = DEF_N_W,
  parameter int unsigned A_W  = DEF_A_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sclk_i,
  input  logic            sdata_i,
  input  logic            le_i,
  output logic [N_W-1:0]  n_o,
  output logic [A_W-1:0]  a_o,
  output logic [SW_W-1:0] sw_o
);
  localparam int unsigned FRAME_W = SW_W + N_W + A_W;

  logic               shift_rise;
  logic [FRAME_W-1:0] frame;

  spr_edge_detect u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_i  (sclk_i),
    .rise_o (shift_rise)
  );

  spr_shift #(.WIDTH(FRAME_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_rise),
    .din      (sdata_i),
    .frame_o  (frame)
  );

  spr_hold #(.SW_W(SW_W), .N_W(N_W), .A_W(A_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .load    (le_i),
    .frame_i (frame),
    .n_o     (n_o),
    .a_o     (a_o),
    .sw_o    (sw_o)
  );

  // R1
  out_reset_chk: assert property (@(posedge clk) rst |=> (n_o == '0 && a_o == '0 && sw_o == '0));
endmodule

// File: tb/serial_prog_reg_bench.sv
module serial_prog_reg_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic sdata = 1'b0;
  logic le = 1'b1;
  logic [9:0] n_o;
  logic [6:0] a_o;
  logic [1:0] sw_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string cur_req = "R1";

  // Reference model state
  bit q[$];
  bit prev_sclk = 1'b1;
  int m_n = 0, m_a = 0, m_sw = 0;

  always #2 clk = ~clk;

  serial_prog_reg u_serial_prog_reg (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sdata_i(sdata), .le_i(le),
    .n_o(n_o), .a_o(a_o), .sw_o(sw_o)
  );

  task automatic model_load();
    m_sw = (int'(q[0]) << 1) | int'(q[1]);
    m_n = 0;
    for (int i = 0; i < 10; i++) m_n = (m_n << 1) | int'(q[2+i]);
    m_a = 0;
    for (int i = 0; i < 7; i++) m_a = (m_a << 1) | int'(q[12+i]);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      q = {};
      for (int i = 0; i < 19; i++) q.push_back(1'b0);
      m_n = 0; m_a = 0; m_sw = 0;
      prev_sclk = 1'b1;
    end else begin
      if (le) model_load();
      if (sclk && !prev_sclk) begin
        q.push_back(sdata);
        void'(q.pop_front());
      end
      prev_sclk = sclk;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison with the model
  always @(negedge clk) begin
    check(cur_req, "n_o", int'(n_o), m_n);
    check(cur_req, "a_o", int'(a_o), m_a);
    check(cur_req, "sw_o", int'(sw_o), m_sw);
  end

  task automatic shift_bit(bit b);
    @(negedge clk); sclk = 1'b0; sdata = b;
    @(negedge clk); sclk = 1'b1;
  endtask

  task automatic shift_frame(bit [18:0] f);
    for (int i = 18; i >= 0; i--) shift_bit(f[i]);
    @(negedge clk); sclk = 1'b0;
  endtask

  task automatic pulse_le();
    @(negedge clk); le = 1'b1;
    @(negedge clk); le = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", "reset n", int'(n_o), 0);
    check("R1", "reset a", int'(a_o), 0);
    check("R1", "reset sw", int'(sw_o), 0);
    le = 1'b0;

    // R3 R8: known frame, sw=10, N=2A5, A=5B
    cur_req = "R3";
    shift_frame({2'b10, 10'h2A5, 7'h5B});
    cur_req = "R5";
    check("R5", "held n before transfer", int'(n_o), 0);
    cur_req = "R4";
    pulse_le();
    check("R3", "n field", int'(n_o), 'h2A5);
    check("R3", "a field", int'(a_o), 'h5B);
    check("R8", "switch order", int'(sw_o), 2);

    // R5: random frames shifted with enable low, then transferred
    for (int k = 0; k < 20; k++) begin
      cur_req = "R5";
      shift_frame(19'($urandom));
      cur_req = "R4";
      pulse_le();
    end

    // R2: shift clock held high, then falling, shifts nothing more
    cur_req = "R2";
    shift_bit(1'b1);
    repeat (10) @(negedge clk);
    sdata = 1'b0;
    repeat (5) @(negedge clk);
    sclk = 1'b0;
    repeat (3) @(negedge clk);
    pulse_le();

    // R2: shift clock high across reset release
    sclk = 1'b1; rst = 1'b1; le = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; sdata = 1'b1;
    repeat (4) @(negedge clk);
    check("R2", "no phantom bit n", int'(n_o), 0);
    check("R2", "no phantom bit sw", int'(sw_o), 0);
    le = 1'b0; sclk = 1'b0;

    // R7: 30 bits shifted, last 19 count
    cur_req = "R7";
    for (int i = 0; i < 11; i++) shift_bit(1'b1);
    shift_frame({2'b01, 10'h155, 7'h2A});
    pulse_le();
    check("R7", "overflow n", int'(n_o), 'h155);
    check("R7", "overflow a", int'(a_o), 'h2A);
    check("R8", "overflow sw", int'(sw_o), 1);

    // R6: shift and transfer on the same edge
    cur_req = "R6";
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); sclk = 1'b0; sdata = k[0];
      @(negedge clk); sclk = 1'b1; le = 1'b1;
      @(negedge clk); le = 1'b0;
    end
    @(negedge clk); sclk = 1'b0;
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule